// File: doc/BRIEF.md
# I2C Byte-Frame Interrupt and Wait Scheduler

This block works next to an I2C shift engine. It counts falling edges of SCL inside each nine-clock byte frame: eight data bits, then the acknowledge bit. At one chosen edge it raises a one-cycle interrupt request and starts a wait, which asks the bus driver to hold SCL low. The chosen edge is the 8th or the 9th. It depends on the current role (master or slave), the phase (address byte or data byte), whether the slave address matched, whether an extension code was received, and a timing-select bit that applies to data bytes.

The wait lasts until one of four release strobes arrives. The four strobes are a control-bit release, a write to the shift register, a start request and a stop request. The block also tells the shift engine when to drive ACK during the acknowledge clock. An addressed slave always acknowledges its own address. A data receiver acknowledges according to the ACK-enable bit. When the wait falls on the 8th edge, the ACK level is taken from ACK-enable in the cycle the wait is released, so software can decide on it during the wait.

Top module: `i2c_irq_wait_ctl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `irq`, `scl_hold` and `ack_drive` are 0.
- R2: In a data byte (`addr_phase`=0), in either role and either direction, the interrupt and wait happen on the 8th SCL falling edge of the frame when `wait_sel9`=0 and on the 9th when `wait_sel9`=1.
- R3: In a master address byte (`is_master`=1, `addr_phase`=1), the interrupt and wait happen on the 9th falling edge whatever the value of `wait_sel9`.
- R4: In a slave address byte, `wait_sel9` has no effect. With `ext_code`=1 the point is the 8th edge. With `ext_code`=0 and `addr_match`=1 it is the 9th edge. With both flags 0 there is neither an interrupt nor a wait in the whole frame.
- R5: `irq` is high for exactly one cycle, the cycle after the clock edge that samples the chosen `scl_fall`. `scl_hold` rises in that same cycle.
- R6: `scl_hold` stays high until a cycle in which any bit of `release_req` is high. Bit 0 is the control-bit release, bit 1 a shift-register write, bit 2 a start request and bit 3 a stop request. `scl_hold` is 0 from the next cycle. A release strobe while no wait is pending changes no output and does not disturb the edge count.
- R7: The edge count returns to zero on `start_det` and after the 9th falling edge, so the next frame starts counting from edge 1.
- R8: `ack_drive` is updated on the 8th falling edge and cleared on the 9th. In a slave address byte with a match and no extension code it is 1 regardless of `ack_en`. For a data receiver (`addr_phase`=0, `is_tx`=0) with the wait on the 9th edge, it equals `ack_en` as sampled at the 8th edge. For a transmitter, a master address byte or an unmatched address, it is 0.
- R9: When the wait falls on the 8th edge and ACK follows `ack_en` (data receiver, or slave with `ext_code`=1), `ack_drive` stays 0 during the wait. It then takes the value `ack_en` has in the release cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_fall | input | 1 | One-cycle strobe per SCL falling edge |
| start_det | input | 1 | One-cycle strobe when a start condition is seen on the bus |
| is_master | input | 1 | 1 = master role, 0 = slave role |
| addr_phase | input | 1 | 1 = address byte, 0 = data byte |
| is_tx | input | 1 | 1 = this device transmits the data byte |
| addr_match | input | 1 | Received address equals the programmed slave address |
| ext_code | input | 1 | Received address is an extension code |
| wait_sel9 | input | 1 | Data-byte timing select: 0 = 8th edge, 1 = 9th edge |
| ack_en | input | 1 | ACK enable for received data |
| release_req | input | NUM_REL | Wait-release strobes (control bit, shift write, start request, stop request) |
| irq | output | 1 | One-cycle interrupt request |
| scl_hold | output | 1 | Request to hold SCL low (wait) |
| ack_drive | output | 1 | Request to drive ACK low on SDA in the acknowledge clock |

## Verification
The bench builds the block with its defaults: FRAME_BITS = 9 and NUM_REL = 4. With these values every release strobe can be driven on its own, and every decoded wait point (8th edge, 9th edge, none) occurs in some role and phase combination. A nine-edge frame keeps both the edge-8 decisions for ACK and the edge-9 wrap within a short directed run. This covers a start that arrives mid-frame and a release strobe that arrives with no wait pending.

// File: rtl/iwc_pkg.sv
package iwc_pkg;

  typedef enum logic [1:0] {
    ACK_OFF    = 2'd0,
    ACK_FORCED = 2'd1,
    ACK_CONFIG = 2'd2
  } ack_mode_e;

  // Edge number of the interrupt/wait point within a frame of `frame` edges;
  // 0 means no interrupt and no wait for this frame.
  function automatic int wait_point(input int frame, input logic master,
                                    input logic addr, input logic sel_last,
                                    input logic match, input logic ext);
    int pt;
    if (!addr)       pt = sel_last ? frame : frame - 1;
    else if (master) pt = frame;
    else if (ext)    pt = frame - 1;
    else if (match)  pt = frame;
    else             pt = 0;
    return pt;
  endfunction

  // Source of the ACK level driven during the acknowledge clock.
  function automatic ack_mode_e ack_mode(input logic master, input logic addr,
                                         input logic tx, input logic match,
                                         input logic ext);
    ack_mode_e m;
    if (addr) begin
      if (master)     m = ACK_OFF;
      else if (ext)   m = ACK_CONFIG;
      else if (match) m = ACK_FORCED;
      else            m = ACK_OFF;
    end else begin
      m = tx ? ACK_OFF : ACK_CONFIG;
    end
    return m;
  endfunction

endpackage

// File: rtl/iwc_bit_counter.sv
module iwc_bit_counter #(
  parameter int FRAME_BITS = 9,
  parameter int CNT_W      = $clog2(FRAME_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_fall,
  input  logic             start_det,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] edge_num,
  output logic             edge_last
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS);

  assign edge_num  = cnt_q + CNT_W'(1);
  assign edge_last = scl_fall && !start_det && (edge_num == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt_q <= '0;
    else if (start_det) cnt_q <= '0;
    else if (edge_last) cnt_q <= '0;
    else if (scl_fall)  cnt_q <= edge_num;
  end

endmodule

// File: rtl/iwc_wait_sched.sv
module iwc_wait_sched #(
  parameter int NUM_REL = 4,
  parameter int CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic [CNT_W-1:0]   edge_num,
  input  logic [CNT_W-1:0]   target,
  input  logic [NUM_REL-1:0] release_req,
  output logic               wait_evt,
  output logic               release_evt,
  output logic               irq_q,
  output logic               hold_q
);

  logic any_rel;

  assign any_rel     = |release_req;
  assign wait_evt    = scl_fall && !start_det && (target != '0) && (edge_num == target);
  assign release_evt = hold_q && any_rel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      irq_q <= wait_evt;
      if (wait_evt)         hold_q <= 1'b1;
      else if (release_evt) hold_q <= 1'b0;
    end
  end

endmodule

// File: rtl/iwc_ack_ctl.sv
module iwc_ack_ctl
  import iwc_pkg::*;
#(
  parameter int FRAME_BITS = 9,
  parameter int CNT_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic [CNT_W-1:0] edge_num,
  input  logic             edge_last,
  input  logic [CNT_W-1:0] target,
  input  ack_mode_e        mode,
  input  logic             ack_en,
  input  logic             release_evt,
  output logic             ack_q,
  output logic             pend_q
);

  localparam logic [CNT_W-1:0] ACK_EDGE = CNT_W'(FRAME_BITS - 1);

  logic edge_ack;

  assign edge_ack = scl_fall && !start_det && (edge_num == ACK_EDGE);

  always_ff @(posedge clk) begin
    if (!rst_n || start_det || edge_last) begin
      ack_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (edge_ack) begin
      unique case (mode)
        ACK_FORCED: begin
          ack_q  <= 1'b1;
          pend_q <= 1'b0;
        end
        ACK_CONFIG: begin
          if (target == ACK_EDGE) begin
            ack_q  <= 1'b0;
            pend_q <= 1'b1;
          end else begin
            ack_q  <= ack_en;
            pend_q <= 1'b0;
          end
        end
        default: begin
          ack_q  <= 1'b0;
          pend_q <= 1'b0;
        end
      endcase
    end else if (pend_q && release_evt) begin
      ack_q  <= ack_en;
      pend_q <= 1'b0;
    end
  end

endmodule

// File: rtl/i2c_irq_wait_ctl.sv
module i2c_irq_wait_ctl
  import iwc_pkg::*;
#(
  parameter int FRAME_BITS = 9,
  parameter int NUM_REL    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               is_master,
  input  logic               addr_phase,
  input  logic               is_tx,
  input  logic               addr_match,
  input  logic               ext_code,
  input  logic               wait_sel9,
  input  logic               ack_en,
  input  logic [NUM_REL-1:0] release_req,
  output logic               irq,
  output logic               scl_hold,
  output logic               ack_drive
);

  localparam int CNT_W = $clog2(FRAME_BITS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] edge_num;
  logic             edge_last;
  logic [CNT_W-1:0] target;
  ack_mode_e        mode;
  logic             wait_evt;
  logic             release_evt;
  logic             pend_q;

  assign target = CNT_W'(wait_point(FRAME_BITS, is_master, addr_phase,
                                    wait_sel9, addr_match, ext_code));
  assign mode   = ack_mode(is_master, addr_phase, is_tx, addr_match, ext_code);

  iwc_bit_counter #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .cnt_q     (cnt_q),
    .edge_num  (edge_num),
    .edge_last (edge_last)
  );

  iwc_wait_sched #(.NUM_REL(NUM_REL), .CNT_W(CNT_W)) u_sched (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_fall    (scl_fall),
    .start_det   (start_det),
    .edge_num    (edge_num),
    .target      (target),
    .release_req (release_req),
    .wait_evt    (wait_evt),
    .release_evt (release_evt),
    .irq_q       (irq),
    .hold_q      (scl_hold)
  );

  iwc_ack_ctl #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_ack (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_fall    (scl_fall),
    .start_det   (start_det),
    .edge_num    (edge_num),
    .edge_last   (edge_last),
    .target      (target),
    .mode        (mode),
    .ack_en      (ack_en),
    .release_evt (release_evt),
    .ack_q       (ack_drive),
    .pend_q      (pend_q)
  );

endmodule

// File: rtl/iwc_checker.sv
module iwc_checker #(
  parameter int FRAME_BITS = 9,
  parameter int NUM_REL    = 4,
  parameter int CNT_W      = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scl_fall,
  input logic               start_det,
  input logic [NUM_REL-1:0] release_req,
  input logic               irq,
  input logic               scl_hold,
  input logic               ack_drive,
  input logic [CNT_W-1:0]   cnt_q,
  input logic               wait_evt
);

  // R5
  irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R5
  irq_with_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> scl_hold);

  // R5
  irq_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(scl_fall));

  // R6
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_hold && !(|release_req)) |=> scl_hold);

  // R6
  hold_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_hold && (|release_req) && !wait_evt) |=> !scl_hold);

  // R6
  hold_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_hold) |-> irq);

  // R7
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(FRAME_BITS));

  // R7
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (cnt_q == '0));

  // R8
  ack_start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !ack_drive);

endmodule

bind i2c_irq_wait_ctl iwc_checker #(
  .FRAME_BITS (FRAME_BITS),
  .NUM_REL    (NUM_REL),
  .CNT_W      (CNT_W)
) u_iwc_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .scl_fall    (scl_fall),
  .start_det   (start_det),
  .release_req (release_req),
  .irq         (irq),
  .scl_hold    (scl_hold),
  .ack_drive   (ack_drive),
  .cnt_q       (cnt_q),
  .wait_evt    (wait_evt)
);

// File: tb/i2c_irq_wait_ctl_bench.sv
`timescale 1ns/1ps
module i2c_irq_wait_ctl_bench;

  localparam int NREL = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            scl_fall = 1'b0;
  logic            start_det = 1'b0;
  logic            is_master = 1'b0;
  logic            addr_phase = 1'b0;
  logic            is_tx = 1'b0;
  logic            addr_match = 1'b0;
  logic            ext_code = 1'b0;
  logic            wait_sel9 = 1'b0;
  logic            ack_en = 1'b0;
  logic [NREL-1:0] release_req = '0;
  logic            irq;
  logic            scl_hold;
  logic            ack_drive;

  int n_run  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  i2c_irq_wait_ctl #(.FRAME_BITS(9), .NUM_REL(NREL)) u_i2c_irq_wait_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_fall    (scl_fall),
    .start_det   (start_det),
    .is_master   (is_master),
    .addr_phase  (addr_phase),
    .is_tx       (is_tx),
    .addr_match  (addr_match),
    .ext_code    (ext_code),
    .wait_sel9   (wait_sel9),
    .ack_en      (ack_en),
    .release_req (release_req),
    .irq         (irq),
    .scl_hold    (scl_hold),
    .ack_drive   (ack_drive)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic fall();
    @(negedge clk) scl_fall = 1'b1;
    @(negedge clk) scl_fall = 1'b0;
  endtask

  task automatic pulse_release(input int idx);
    release_req = '0;
    release_req[idx] = 1'b1;
    @(negedge clk) release_req = '0;
  endtask

  task automatic reset_check();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "irq in reset", int'(irq), 0);
    check("R1", "hold in reset", int'(scl_hold), 0);
    check("R1", "ack in reset", int'(ack_drive), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "irq after reset", int'(irq), 0);
    check("R1", "hold after reset", int'(scl_hold), 0);
    check("R1", "ack after reset", int'(ack_drive), 0);
  endtask

  // One full frame of nine edges with its own expected timing and ACK model.
  task automatic run_frame(input string tag, input logic m, input logic a, input logic tx,
                           input logic sel, input logic match, input logic ext,
                           input logic ack0, input logic ack1, input int rel);
    int  ep;
    bit  forced;
    bit  cfg;
    int  ea8;
    is_master = m; addr_phase = a; is_tx = tx; wait_sel9 = sel;
    addr_match = match; ext_code = ext; ack_en = ack0;
    if (!a)        ep = sel ? 9 : 8;
    else if (m)    ep = 9;
    else if (ext)  ep = 8;
    else if (match) ep = 9;
    else           ep = 0;
    forced = a && !m && !ext && match;
    cfg    = (a && !m && ext) || (!a && !tx);
    if (forced)        ea8 = 1;
    else if (cfg)      ea8 = (ep == 8) ? 0 : int'(ack0);
    else               ea8 = 0;
    for (int k = 1; k <= 9; k++) begin
      fall();
      check(tag, $sformatf("irq at edge %0d", k), int'(irq), int'(k == ep));
      check(tag, $sformatf("hold at edge %0d", k), int'(scl_hold), int'(k == ep));
      if (k == 8)
        check((cfg && ep == 8) ? "R9" : "R8", "ack at edge 8", int'(ack_drive), ea8);
      if (k == ep) begin
        @(negedge clk);
        check("R5", "irq one cycle later", int'(irq), 0);
        check("R6", "hold kept before release", int'(scl_hold), 1);
        ack_en = ack1;
        pulse_release(rel);
        check("R6", $sformatf("hold after release bit %0d", rel), int'(scl_hold), 0);
        if (k == 8 && cfg)
          check("R9", "ack sampled at release", int'(ack_drive), int'(ack1));
        if (k == 8 && forced)
          check("R8", "forced ack kept after release", int'(ack_drive), 1);
      end
      if (k == 9)
        check("R8", "ack cleared at edge 9", int'(ack_drive), 0);
    end
  endtask

  task automatic release_without_wait();
    for (int i = 0; i < NREL; i++) begin
      pulse_release(i);
      check("R6", $sformatf("idle release %0d hold", i), int'(scl_hold), 0);
      check("R6", $sformatf("idle release %0d irq", i), int'(irq), 0);
    end
    // Count must be untouched: a data frame still waits on the 8th edge.
    run_frame("R6", 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3);
  endtask

  task automatic start_mid_frame();
    is_master = 1'b1; addr_phase = 1'b0; is_tx = 1'b1; wait_sel9 = 1'b0;
    ext_code = 1'b0; addr_match = 1'b0; ack_en = 1'b0;
    repeat (3) fall();
    @(negedge clk) start_det = 1'b1;
    @(negedge clk) start_det = 1'b0;
    for (int k = 1; k <= 8; k++) begin
      fall();
      check("R7", $sformatf("irq at edge %0d after start", k), int'(irq), int'(k == 8));
    end
    @(negedge clk);
    pulse_release(2);
    fall();
    check("R7", "no irq at edge 9", int'(irq), 0);
    // Frame boundary: the next frame waits on its own 9th edge.
    run_frame("R7", 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    reset_check();
    // R2 master receive, 8th edge, ACK decided during wait
    run_frame("R2", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 0);
    // R2 master transmit, 9th edge
    run_frame("R2", 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1);
    // R3 master address with select 0 still on 9th edge
    run_frame("R3", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2);
    // R4 slave address match, ACK forced with ack_en 0
    run_frame("R4", 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3);
    // R4 slave address mismatch: nothing
    run_frame("R4", 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 0);
    // R4 extension code: 8th edge even with select 1
    run_frame("R4", 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 0);
    // R2 slave receive 9th edge, ACK from edge-8 sample
    run_frame("R2", 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1);
    // R2 slave transmit, 8th edge
    run_frame("R2", 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2);
    release_without_wait();
    start_mid_frame();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule